// File: doc/BRIEF.md
# Halfword, Signed-Byte and Doubleword Address Unit

This block handles the address side of the load/store encoding used for halfword, signed byte and doubleword transfers. It takes a 4-bit operation code and five mode bits: pre-index, add, immediate, update and load. It also takes the base register value, the offset register value, and an 8-bit immediate that arrives as two nibbles. From these it works out the effective address, the base update value and its enable, the transfer kind, and an undefined flag.

The same cycle, it also formats the raw memory word for a load into one or two destination register values, and packs the source register values into a store word.

All results are captured together in one register stage and are qualified by `out_valid`. The pipeline that uses the block presents one instruction, together with its operand values and its load data, with `in_valid` high. It reads the decoded result on the following cycle.

Top module: `am3_addr_unit`

## Requirements
- R1: Offset selection. With `ofs_imm`=1 the offset is {`imm_hi`,`imm_lo`} zero-extended to 32 bits; otherwise it is `offs_val`. The sum `delta` is `base_val`+offset when `ofs_add`=1 and `base_val`-offset when it is 0, both modulo 2^32.
- R2: `ea` equals `delta` when `idx_pre`=1 and equals the unmodified `base_val` when `idx_pre`=0.
- R3: `wb_val` always equals `delta`. `wb_en` is 1 exactly when the instruction is legal and (`idx_pre`=0 or `base_upd`=1), so with `idx_pre`=1 and `base_upd`=0 there is no update.
- R4: `undef` is 1 when `op` is not 0xB, 0xD or 0xF, or when `idx_pre`=0 with `base_upd`=1. An undefined instruction forces `wb_en`, `xfer_size`, `xfer_signed`, `xfer_load`, `xfer_pair`, `reg_lo`, `reg_hi`, `ld_lo`, `ld_hi` and `st_data` to zero.
- R5: Op 0xB, load=0: store halfword, size 1, and `st_data` = `src_lo`[15:0] zero-extended. Op 0xB, load=1: load halfword, size 1, and `ld_lo` = `ld_data`[15:0] zero-extended. Size encoding: 0 byte, 1 halfword, 3 doubleword.
- R6: Op 0xD, load=0: doubleword load with pair=1, `ld_lo` = `ld_data`[31:0] and `ld_hi` = `ld_data`[63:32]. Op 0xD, load=1: signed byte load, size 0, signed=1, and `ld_lo` = `ld_data`[7:0] sign-extended.
- R7: Op 0xF, load=0: doubleword store with pair=1 and `st_data` = {`src_hi`,`src_lo`}. Op 0xF, load=1: signed halfword load, size 1, and `ld_lo` = `ld_data`[15:0] sign-extended.
- R8: In the pair forms, `reg_lo` = `rd_idx` with bit 0 cleared and `reg_hi` = `reg_lo`+1. In single forms, `reg_lo` = `rd_idx` and `reg_hi` = 0. Outputs that a form does not use (`ld_hi` outside pair loads, `ld_lo`/`ld_hi` for stores, `st_data` for loads) are 0.
- R9: Every output is registered. A cycle with `in_valid`=1 updates all outputs on the next edge, and `out_valid` follows `in_valid` by one cycle. With `in_valid`=0 the outputs hold. Reset clears `out_valid` and every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| op | input | 4 | Operation code (0xB, 0xD, 0xF legal) |
| idx_pre | input | 1 | 1: pre-indexed, 0: post-indexed |
| ofs_add | input | 1 | 1: add offset, 0: subtract |
| ofs_imm | input | 1 | 1: immediate offset, 0: register offset |
| base_upd | input | 1 | Update request bit |
| dir_load | input | 1 | Load bit selecting the pair member |
| base_val | input | 32 | Base register value |
| offs_val | input | 32 | Offset register value |
| imm_hi | input | 4 | Immediate high nibble |
| imm_lo | input | 4 | Immediate low nibble |
| rd_idx | input | 4 | Destination/source register number |
| src_lo | input | 32 | Source value of the (even) register |
| src_hi | input | 32 | Source value of the odd register |
| ld_data | input | 64 | Raw memory data for loads |
| out_valid | output | 1 | Outputs updated last cycle |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base update enable |
| wb_val | output | 32 | Base update value |
| undef | output | 1 | Undefined instruction |
| xfer_size | output | 2 | 0 byte, 1 halfword, 3 doubleword |
| xfer_signed | output | 1 | Sign-extending load |
| xfer_load | output | 1 | Transfer is a load |
| xfer_pair | output | 1 | Transfer uses a register pair |
| reg_lo | output | 4 | First (even) register number |
| reg_hi | output | 4 | Odd register number of a pair |
| ld_lo | output | 32 | Formatted load value for reg_lo |
| ld_hi | output | 32 | Load value for reg_hi |
| st_data | output | 64 | Packed store data |

## Verification
The bench builds the block with its default parameters: a 32-bit address and data width, 4-bit register numbers and an 8-bit immediate. This keeps the modulo-2^32 address arithmetic observable at the ports. Directed cases cover wrap-around below zero and above the top of the address space, post-indexing, the illegal post-index-with-update case and unlisted op codes. They also cover an odd register number in a pair form, and the hold behaviour when `in_valid` is low. Random cases cover all 32 mode combinations under each op code. The sign and zero extensions are exercised with byte and halfword values that have their top bits set.

// File: rtl/am3_addr_unit.sv
module am3_addr_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RIDX_W = 4,
  parameter int IMM_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [3:0]            op,
  input  logic                  idx_pre,
  input  logic                  ofs_add,
  input  logic                  ofs_imm,
  input  logic                  base_upd,
  input  logic                  dir_load,
  input  logic [ADDR_W-1:0]     base_val,
  input  logic [ADDR_W-1:0]     offs_val,
  input  logic [IMM_W/2-1:0]    imm_hi,
  input  logic [IMM_W/2-1:0]    imm_lo,
  input  logic [RIDX_W-1:0]     rd_idx,
  input  logic [DATA_W-1:0]     src_lo,
  input  logic [DATA_W-1:0]     src_hi,
  input  logic [2*DATA_W-1:0]   ld_data,
  output logic                  out_valid,
  output logic [ADDR_W-1:0]     ea,
  output logic                  wb_en,
  output logic [ADDR_W-1:0]     wb_val,
  output logic                  undef,
  output logic [1:0]            xfer_size,
  output logic                  xfer_signed,
  output logic                  xfer_load,
  output logic                  xfer_pair,
  output logic [RIDX_W-1:0]     reg_lo,
  output logic [RIDX_W-1:0]     reg_hi,
  output logic [DATA_W-1:0]     ld_lo,
  output logic [DATA_W-1:0]     ld_hi,
  output logic [2*DATA_W-1:0]   st_data
);
  localparam logic [3:0] OP_HALF = 4'hB;
  localparam logic [3:0] OP_DLSB = 4'hD;
  localparam logic [3:0] OP_DSSH = 4'hF;
  localparam int PAIR_W = 2 * DATA_W;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_DWRD = 2'd3;

  logic [ADDR_W-1:0] ofs, delta;
  logic              op_ok, illegal;

  assign ofs     = ofs_imm ? {{(ADDR_W-IMM_W){1'b0}}, imm_hi, imm_lo} : offs_val;
  assign delta   = ofs_add ? base_val + ofs : base_val - ofs;
  assign op_ok   = (op == OP_HALF) || (op == OP_DLSB) || (op == OP_DSSH);
  assign illegal = !op_ok || (!idx_pre && base_upd);

  logic [1:0]        n_size;
  logic              n_sgn, n_ld, n_pair;
  logic [RIDX_W-1:0] n_rlo, n_rhi;
  logic [DATA_W-1:0] n_llo, n_lhi;
  logic [PAIR_W-1:0] n_st;
  logic [RIDX_W-1:0] even_idx;

  assign even_idx = {rd_idx[RIDX_W-1:1], 1'b0};

  always_comb begin
    n_size = SZ_BYTE;
    n_sgn  = 1'b0;
    n_ld   = 1'b0;
    n_pair = 1'b0;
    n_rlo  = '0;
    n_rhi  = '0;
    n_llo  = '0;
    n_lhi  = '0;
    n_st   = '0;
    if (!illegal) begin
      n_rlo = rd_idx;
      unique case (op)
        OP_HALF: begin
          n_size = SZ_HALF;
          n_ld   = dir_load;
          if (dir_load) n_llo = {{(DATA_W-16){1'b0}}, ld_data[15:0]};
          else          n_st  = {{(PAIR_W-16){1'b0}}, src_lo[15:0]};
        end
        OP_DLSB: begin
          n_ld = 1'b1;
          if (dir_load) begin
            n_size = SZ_BYTE;
            n_sgn  = 1'b1;
            n_llo  = {{(DATA_W-8){ld_data[7]}}, ld_data[7:0]};
          end else begin
            n_size = SZ_DWRD;
            n_pair = 1'b1;
            n_rlo  = even_idx;
            n_rhi  = even_idx + 1'b1;
            n_llo  = ld_data[DATA_W-1:0];
            n_lhi  = ld_data[PAIR_W-1:DATA_W];
          end
        end
        default: begin
          if (dir_load) begin
            n_size = SZ_HALF;
            n_sgn  = 1'b1;
            n_ld   = 1'b1;
            n_llo  = {{(DATA_W-16){ld_data[15]}}, ld_data[15:0]};
          end else begin
            n_size = SZ_DWRD;
            n_pair = 1'b1;
            n_rlo  = even_idx;
            n_rhi  = even_idx + 1'b1;
            n_st   = {src_hi, src_lo};
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      ea          <= '0;
      wb_en       <= 1'b0;
      wb_val      <= '0;
      undef       <= 1'b0;
      xfer_size   <= '0;
      xfer_signed <= 1'b0;
      xfer_load   <= 1'b0;
      xfer_pair   <= 1'b0;
      reg_lo      <= '0;
      reg_hi      <= '0;
      ld_lo       <= '0;
      ld_hi       <= '0;
      st_data     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea          <= idx_pre ? delta : base_val;
        wb_en       <= !illegal && (!idx_pre || base_upd);
        wb_val      <= delta;
        undef       <= illegal;
        xfer_size   <= n_size;
        xfer_signed <= n_sgn;
        xfer_load   <= n_ld;
        xfer_pair   <= n_pair;
        reg_lo      <= n_rlo;
        reg_hi      <= n_rhi;
        ld_lo       <= n_llo;
        ld_hi       <= n_lhi;
        st_data     <= n_st;
      end
    end
  end

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ea) && $stable(wb_en) && $stable(undef));

  p_post_ea_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !idx_pre && !base_upd |=> ea == $past(base_val));

  p_pre_no_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && idx_pre && !base_upd |=> !wb_en);

  p_illegal_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !idx_pre && base_upd |=> undef && !wb_en);

  p_undef_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && undef |-> !wb_en && !xfer_load && !xfer_pair && st_data == '0);

  p_pair_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && xfer_pair |-> !reg_lo[0] && reg_hi == reg_lo + 1'b1);
endmodule

// File: tb/am3_addr_unit_tb.sv
module am3_addr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        idx_pre = 0, ofs_add = 0, ofs_imm = 0, base_upd = 0, dir_load = 0;
  logic [31:0] base_val = '0, offs_val = '0, src_lo = '0, src_hi = '0;
  logic [3:0]  imm_hi = '0, imm_lo = '0, rd_idx = '0;
  logic [63:0] ld_data = '0;
  logic        out_valid, wb_en, undef, xfer_signed, xfer_load, xfer_pair;
  logic [31:0] ea, wb_val, ld_lo, ld_hi;
  logic [1:0]  xfer_size;
  logic [3:0]  reg_lo, reg_hi;
  logic [63:0] st_data;

  am3_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .idx_pre(idx_pre), .ofs_add(ofs_add), .ofs_imm(ofs_imm),
    .base_upd(base_upd), .dir_load(dir_load), .base_val(base_val),
    .offs_val(offs_val), .imm_hi(imm_hi), .imm_lo(imm_lo), .rd_idx(rd_idx),
    .src_lo(src_lo), .src_hi(src_hi), .ld_data(ld_data),
    .out_valid(out_valid), .ea(ea), .wb_en(wb_en), .wb_val(wb_val),
    .undef(undef), .xfer_size(xfer_size), .xfer_signed(xfer_signed),
    .xfer_load(xfer_load), .xfer_pair(xfer_pair), .reg_lo(reg_lo),
    .reg_hi(reg_hi), .ld_lo(ld_lo), .ld_hi(ld_hi), .st_data(st_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_delta(logic u, logic i, logic [31:0] b,
                                          logic [31:0] r, logic [7:0] im);
    logic [31:0] o;
    o = i ? {24'd0, im} : r;
    return u ? b + o : b - o;
  endfunction

  task automatic run(logic [3:0] t_op, logic p, logic u, logic i, logic w, logic l,
                     logic [31:0] b, logic [31:0] r, logic [7:0] im, logic [3:0] rd,
                     logic [31:0] sl, logic [31:0] sh, logic [63:0] ld);
    logic [31:0] d, e_llo, e_lhi;
    logic [63:0] e_st;
    logic legal, e_sgn, e_ld, e_pair;
    logic [1:0] e_sz;
    logic [3:0] e_rlo, e_rhi;
    string kt;
    in_valid = 1; op = t_op; idx_pre = p; ofs_add = u; ofs_imm = i;
    base_upd = w; dir_load = l; base_val = b; offs_val = r;
    imm_hi = im[7:4]; imm_lo = im[3:0]; rd_idx = rd; src_lo = sl; src_hi = sh;
    ld_data = ld;
    d = f_delta(u, i, b, r, im);
    legal = (t_op == 4'hB || t_op == 4'hD || t_op == 4'hF) && !(!p && w);
    e_sz = 0; e_sgn = 0; e_ld = 0; e_pair = 0; e_rlo = 0; e_rhi = 0;
    e_llo = 0; e_lhi = 0; e_st = 0; kt = "R4";
    if (legal) begin
      e_rlo = rd;
      if (t_op == 4'hB) begin
        kt = "R5"; e_sz = 1; e_ld = l;
        if (l) e_llo = {16'd0, ld[15:0]}; else e_st = {48'd0, sl[15:0]};
      end else if (t_op == 4'hD) begin
        kt = "R6"; e_ld = 1;
        if (l) begin e_sgn = 1; e_llo = {{24{ld[7]}}, ld[7:0]}; end
        else begin
          e_sz = 3; e_pair = 1; e_rlo = {rd[3:1], 1'b0}; e_rhi = e_rlo + 1;
          e_llo = ld[31:0]; e_lhi = ld[63:32];
        end
      end else begin
        kt = "R7";
        if (l) begin e_sz = 1; e_sgn = 1; e_ld = 1; e_llo = {{16{ld[15]}}, ld[15:0]}; end
        else begin
          e_sz = 3; e_pair = 1; e_rlo = {rd[3:1], 1'b0}; e_rhi = e_rlo + 1;
          e_st = {sh, sl};
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R9 out_valid", 64'(out_valid), 64'd1);
    chk("R2 ea", 64'(ea), 64'(p ? d : b));
    chk("R1/R3 wb_val", 64'(wb_val), 64'(d));
    chk("R3 wb_en", 64'(wb_en), 64'(legal && (!p || w)));
    chk("R4 undef", 64'(undef), 64'(!legal));
    chk({kt, " kind"}, {58'd0, xfer_size, xfer_signed, xfer_load, xfer_pair, 1'b0},
        {58'd0, e_sz, e_sgn, e_ld, e_pair, 1'b0});
    chk("R8 regs", {56'd0, reg_hi, reg_lo}, {56'd0, e_rhi, e_rlo});
    chk({kt, " ld_lo"}, 64'(ld_lo), 64'(e_llo));
    chk({kt, " ld_hi"}, 64'(ld_hi), 64'(e_lhi));
    chk({kt, " st_data"}, st_data, e_st);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold_ea;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", 64'(out_valid), 0);
    chk("R9 reset ea", 64'(ea), 0);
    chk("R9 reset st_data", st_data, 0);
    chk("R9 reset wb_en", 64'(wb_en), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 R2: pre-indexed immediate subtract wraps below zero
    run(4'hB, 1, 0, 1, 0, 1, 32'h0, 32'h5, 8'h01, 4'd3, 0, 0, 64'h8001);
    // R1: pre-indexed register add wraps past the top
    run(4'hB, 1, 1, 0, 1, 0, 32'hFFFF_FFF0, 32'h20, 8'hFF, 4'd2, 32'hABCD_8765, 0, 0);
    // R2 R3: post-indexed, split immediate
    run(4'hD, 0, 1, 1, 0, 1, 32'h1000, 32'h0, 8'hA5, 4'd7, 0, 0, 64'h80);
    // R4: illegal post-index with update
    run(4'hF, 0, 1, 0, 1, 0, 32'h2000, 32'h4, 8'h0, 4'd4, 1, 2, 64'h1);
    // R4: unlisted op code
    run(4'h3, 1, 1, 1, 1, 1, 32'h3000, 32'h4, 8'h10, 4'd4, 1, 2, 64'hFFFF);
    // R6 R8: doubleword load with odd register number
    run(4'hD, 1, 1, 1, 0, 0, 32'h40, 0, 8'h08, 4'd5, 0, 0, 64'h1122_3344_5566_7788);
    // R7 R8: doubleword store
    run(4'hF, 1, 0, 0, 1, 0, 32'h100, 32'h8, 0, 4'd9, 32'hCAFE_0001, 32'hBEEF_0002, 0);
    // R7: signed halfword with sign set
    run(4'hF, 1, 1, 1, 1, 1, 32'h100, 0, 8'h02, 4'd1, 0, 0, 64'h0000_0000_0000_9234);
    // R9: outputs hold while in_valid is low
    hold_ea = ea;
    base_val = 32'h5555_0000; idx_pre = 0; op = 4'h0;
    @(posedge clk); @(negedge clk);
    chk("R9 idle out_valid", 64'(out_valid), 0);
    chk("R9 idle ea hold", 64'(ea), 64'(hold_ea));
    chk("R9 idle undef hold", 64'(undef), 0);
    for (int k = 0; k < 600; k++) begin
      logic [3:0] o;
      logic [4:0] m;
      m = 5'(k % 32);
      case ($urandom % 4)
        0: o = 4'hB;
        1: o = 4'hD;
        2: o = 4'hF;
        default: o = 4'($urandom);
      endcase
      run(o, m[4], m[3], m[2], m[1], m[0], $urandom, $urandom, 8'($urandom),
          4'($urandom), $urandom, $urandom, {$urandom, $urandom});
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule